// File: doc/BRIEF.md
# Receive Pad and FCS Stripper

This block sits in a receive path after the preamble has been removed. It takes a byte stream with start-of-frame and end-of-frame markers and delivers the same bytes in order. Depending on two enable inputs, it drops Ethernet padding, the 4-byte frame check sequence, or both. The length/type value is read from the frame itself, at byte offsets 12 (high byte) and 13 (low byte).

A CRC-32 runs over every received byte, FCS included. For each frame a status strobe reports whether the CRC was good and how many bytes were delivered. Bytes that could still turn out to be padding or FCS are held in a circular buffer. They are released as soon as they are known to be kept. Once the end marker shows the frame's total length, the write pointer is rewound over the discarded tail.

Top module: `rx_pad_fcs_trim`

## Requirements
- R1: After reset, `out_valid`, `out_eof` and `stat_valid` are low, and they stay low until a frame is received.
- R2: With both enables low, every input frame is delivered byte for byte, in the order received, FCS included.
- R3: With `fcs_strip_en` high, the last 4 bytes of every frame are removed, whatever the frame's length or its length/type value.
- R4: Padding is removed when all of these hold: `pad_strip_en` is high, the total frame length L is at most 127, and the length/type value N (big-endian at offsets 12 and 13) is below 1536 and satisfies 14+N < L-4. The frame is then cut to its first 14+N bytes, and its FCS is dropped even when `fcs_strip_en` is low.
- R5: A frame of 128 bytes or more never has padding removed. Only the FCS can be removed from such a frame.
- R6: When the length/type value is 1536 or more, it is a type and no padding is removed.
- R7: With `pad_strip_en` high and `fcs_strip_en` low, a frame that has no padding (14+N = L-4) keeps its FCS and is delivered whole.
- R8: `stat_crc_ok` is high exactly when the reflected CRC-32 register leaves the residue 0xDEBB20E3. That register uses polynomial 0x04C11DB7, starts at all ones and runs over all received bytes, FCS included. 0xDEBB20E3 is 0xC704DD7B in reflected form. The check is made even when the FCS is not delivered.
- R9: `stat_valid` pulses for one cycle, in the cycle after the input end byte, and `stat_len` gives the number of bytes that frame delivers.
- R10: `out_eof` is high with the last delivered byte of each frame and only then. The number of output bytes per frame equals `stat_len`. Frames sent back to back, or with idle cycles inside them, come out in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_strip_en | input | 1 | Enable padding removal |
| fcs_strip_en | input | 1 | Enable FCS removal on every frame |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_eof | output | 1 | Output byte is the last delivered byte of its frame |
| stat_valid | output | 1 | Per-frame status strobe |
| stat_crc_ok | output | 1 | CRC of the frame was good |
| stat_len | output | CNT_W (12) | Number of delivered bytes of the frame |

## Verification
The assertions assume well-formed input. Every frame starts with a start marker and ends with one end marker. Frames are between 64 and MAX_FRAME bytes long. The enables do not change while a frame is being received. Under those conditions the buffer can never wrap onto unread bytes. The stimulus sends only complete frames of 64 to 150 bytes, and it sets the enables between frames, while the input is idle. Idle cycles are placed inside one frame and no gap is left between two back-to-back frames, to exercise both the hold-back path and the rewind path.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int unsigned ETH_HDR_BYTES = 14;
  localparam int unsigned FCS_BYTES     = 4;
  localparam int unsigned TYPE_MIN      = 1536;
  localparam int unsigned PAD_LIMIT     = 128;
  localparam logic [31:0] CRC_POLY_REFL    = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE_REFL = 32'hDEBB20E3;

  // One byte of the reflected CRC-32, LSB of the byte first
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // Delivered byte count of a finished frame of 'total' bytes
  function automatic int unsigned keep_length(input int unsigned total, input int unsigned lt,
                                              input logic pad_en, input logic fcs_en);
    int unsigned want;
    want = ETH_HDR_BYTES + lt;
    if (pad_en && total < PAD_LIMIT && lt < TYPE_MIN && want + FCS_BYTES < total) return want;
    if (fcs_en) return total - FCS_BYTES;
    return total;
  endfunction

  // Bytes of a frame in progress that are certainly kept and are not the
  // final kept byte (which waits for the end marker to carry the end flag)
  function automatic int unsigned safe_length(input int unsigned seen, input int unsigned lt,
                                              input logic pad_en);
    int unsigned s;
    s = (seen > FCS_BYTES + 1) ? seen - (FCS_BYTES + 1) : 0;
    if (pad_en && seen < PAD_LIMIT && seen >= ETH_HDR_BYTES && lt < TYPE_MIN &&
        s + 1 > ETH_HDR_BYTES + lt)
      s = ETH_HDR_BYTES + lt - 1;
    return s;
  endfunction
endpackage

// File: rtl/rxs_crc_acc.sv
module rxs_crc_acc
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              sof,
  input  logic [DATA_W-1:0] data,
  output logic              good
);
  logic [31:0] crc_q;
  logic [31:0] crc_seed;
  logic [31:0] crc_nxt;

  assign crc_seed = sof ? 32'hFFFF_FFFF : crc_q;
  assign crc_nxt  = crc32_step(crc_seed, data);
  assign good     = (crc_nxt == CRC_RESIDUE_REFL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= 32'hFFFF_FFFF;
    else if (push) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/rxs_hdr_track.sv
module rxs_hdr_track #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 12,
  parameter int LT_POS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              sof,
  input  logic              last,
  input  logic [DATA_W-1:0] data,
  output logic [CNT_W-1:0]  seen,
  output logic [15:0]       lentype
);
  localparam logic [CNT_W-1:0] HI_IDX = CNT_W'(LT_POS);
  localparam logic [CNT_W-1:0] LO_IDX = CNT_W'(LT_POS + 1);

  logic [CNT_W-1:0] idx;
  assign idx = sof ? '0 : seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= '0;
      lentype <= '0;
    end else if (push) begin
      seen <= last ? '0 : idx + CNT_W'(1);
      if (idx == HI_IDX) lentype[15:8] <= data[7:0];
      if (idx == LO_IDX) lentype[7:0]  <= data[7:0];
    end
  end
endmodule

// File: rtl/rxs_hold_buf.sv
module rxs_hold_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              last,
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  safe_len,
  input  logic [CNT_W-1:0]  keep_len,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_eof
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  endmark;
  logic [PTR_W-1:0]  wr_q, rd_q, start_q, commit_q;
  logic [PTR_W-1:0]  keep_end, safe_ptr, occupancy, committed;
  logic              can_read;

  assign keep_end  = start_q + keep_len[PTR_W-1:0];
  assign safe_ptr  = start_q + safe_len[PTR_W-1:0];
  assign can_read  = (rd_q != commit_q);
  assign occupancy = wr_q - rd_q;
  assign committed = commit_q - rd_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= '0;
      rd_q      <= '0;
      start_q   <= '0;
      commit_q  <= '0;
      endmark   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eof   <= 1'b0;
    end else begin
      if (push) endmark[wr_q] <= 1'b0;
      if (push && last) begin
        endmark[keep_end - PTR_W'(1)] <= 1'b1;
        wr_q     <= keep_end;
        start_q  <= keep_end;
        commit_q <= keep_end;
      end else begin
        if (push) wr_q <= wr_q + PTR_W'(1);
        commit_q <= safe_ptr;
      end
      if (can_read) begin
        out_valid <= 1'b1;
        out_data  <= mem[rd_q];
        out_eof   <= endmark[rd_q];
        rd_q      <= rd_q + PTR_W'(1);
      end else begin
        out_valid <= 1'b0;
        out_eof   <= 1'b0;
      end
    end
  end

  // R10: the releasable region never reaches beyond the written region
  p_commit_within_r10: assert property (@(posedge clk) disable iff (!rst_n)
    committed <= occupancy);
  // R2: unread bytes never fill the whole ring
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy != PTR_W'(DEPTH - 1));
  // R10: the end flag is raised only with a delivered byte
  p_eof_with_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);
endmodule

// File: rtl/rx_pad_fcs_trim.sv
module rx_pad_fcs_trim
  import rxs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_FRAME = 2048,
  parameter int DEPTH     = 256,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pad_strip_en,
  input  logic              fcs_strip_en,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_eof,
  output logic              stat_valid,
  output logic              stat_crc_ok,
  output logic [CNT_W-1:0]  stat_len
);
  logic [CNT_W-1:0] seen;
  logic [15:0]      lentype;
  logic [CNT_W-1:0] frame_len, safe_len, keep_len;
  logic             crc_good, frame_end;

  assign frame_end = in_valid && in_eof;
  assign frame_len = seen + CNT_W'(1);
  assign safe_len  = CNT_W'(safe_length(int'(seen), int'(lentype), pad_strip_en));
  assign keep_len  = CNT_W'(keep_length(int'(frame_len), int'(lentype),
                                        pad_strip_en, fcs_strip_en));

  rxs_hdr_track #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LT_POS(12)) u_trk (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .sof(in_sof), .last(in_eof),
    .data(in_data), .seen(seen), .lentype(lentype));

  rxs_crc_acc #(.DATA_W(DATA_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .sof(in_sof), .data(in_data),
    .good(crc_good));

  rxs_hold_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .last(in_eof), .din(in_data),
    .safe_len(safe_len), .keep_len(keep_len),
    .out_valid(out_valid), .out_data(out_data), .out_eof(out_eof));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid  <= 1'b0;
      stat_crc_ok <= 1'b0;
      stat_len    <= '0;
    end else begin
      stat_valid <= frame_end;
      if (frame_end) begin
        stat_crc_ok <= crc_good;
        stat_len    <= keep_len;
      end
    end
  end

  // R3: FCS removal takes at least four bytes off the frame
  p_fcs_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && $past(fcs_strip_en) |-> int'(stat_len) + 4 <= int'($past(frame_len)));
  // R5: long frames lose at most the FCS
  p_long_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && $past(frame_len) >= CNT_W'(128) |->
      int'(stat_len) + 4 >= int'($past(frame_len)));
  // R6: type frames lose at most the FCS
  p_type_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && $past(lentype) >= 16'd1536 |->
      int'(stat_len) + 4 >= int'($past(frame_len)));
endmodule

// File: tb/rx_pad_fcs_trim_tb.sv
`timescale 1ns/1ps
module rx_pad_fcs_trim_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pad_en = 1'b0, fcs_en = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, out_eof, stat_valid, stat_crc_ok;
  logic [7:0] out_data;
  logic [11:0] stat_len;

  always #4 clk = ~clk;

  rx_pad_fcs_trim u_dut (
    .clk(clk), .rst_n(rst_n), .pad_strip_en(pad_en), .fcs_strip_en(fcs_en),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_eof(out_eof),
    .stat_valid(stat_valid), .stat_crc_ok(stat_crc_ok), .stat_len(stat_len));

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] frm [512];
  logic [7:0] rx_buf [512];
  int rx_cnt = 0, rx_eofs = 0;
  int eof_pos [8];
  int st_cnt = 0;
  int st_len [8];
  logic st_ok [8];

  always @(negedge clk) begin
    if (out_valid) begin
      rx_buf[rx_cnt] = out_data;
      rx_cnt = rx_cnt + 1;
      if (out_eof) begin eof_pos[rx_eofs] = rx_cnt; rx_eofs = rx_eofs + 1; end
    end
    if (stat_valid) begin
      st_len[st_cnt] = int'(stat_len); st_ok[st_cnt] = stat_crc_ok;
      st_cnt = st_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fcs_of(input int base, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = frm[base + i];
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ d[b];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic build(input int base, input int total, input int lt, input bit bad);
    int pay = (lt < 1536) ? lt : total - 18;
    logic [31:0] f;
    for (int i = 0; i < total - 4; i++) begin
      if (i < 12)           frm[base + i] = 8'hA0 ^ 8'(i);
      else if (i == 12)     frm[base + i] = 8'(lt >> 8);
      else if (i == 13)     frm[base + i] = 8'(lt);
      else if (i < 14 + pay) frm[base + i] = 8'(i * 7 + 3);
      else                  frm[base + i] = 8'h00;
    end
    f = fcs_of(base, total - 4);
    for (int k = 0; k < 4; k++) frm[base + total - 4 + k] = f[8*k +: 8];
    if (bad) frm[base + 20] = frm[base + 20] ^ 8'h5A;
  endtask

  task automatic send(input int base, input int total, input bit gaps);
    for (int i = 0; i < total; i++) begin
      if (gaps && (i % 5 == 4)) begin @(negedge clk); in_valid = 1'b0; end
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == total - 1);
      in_data = frm[base + i];
    end
    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic clear_rx();
    @(posedge clk);
    rx_cnt = 0; rx_eofs = 0; st_cnt = 0;
  endtask

  task automatic compare(input string tag, input int rx_off, input int base, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (rx_buf[rx_off + i] !== frm[base + i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  // One frame: send, let the buffer drain, check bytes, end marker and status
  task automatic run_frame(input string tag, input int total, input int lt, input bit p,
                           input bit f, input bit bad, input bit gaps, input int exp_len);
    pad_en = p; fcs_en = f;
    build(0, total, lt, bad);
    clear_rx();
    send(0, total, gaps);
    repeat (300) @(posedge clk);
    chk(rx_cnt == exp_len, {tag, " byte count"}, rx_cnt, exp_len);
    compare({tag, " byte content"}, 0, 0, exp_len);
    chk(rx_eofs == 1 && eof_pos[0] == exp_len, {tag, " R10 end marker"}, eof_pos[0], exp_len);
    chk(st_cnt == 1 && st_len[0] == exp_len, {tag, " R9 stat_len"}, st_len[0], exp_len);
    chk(st_ok[0] == !bad, {tag, " R8 crc flag"}, int'(st_ok[0]), int'(!bad));
  endtask

  task automatic t_reset_r1();
    chk(out_valid == 0 && out_eof == 0 && stat_valid == 0, "R1 outputs during reset",
        int'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(out_valid == 0 && stat_valid == 0, "R1 outputs idle after reset", int'(out_valid), 0);
  endtask

  // Back to back (R10): A cut to 34 by padding rule, B keeps 60 (FCS off only)
  task automatic t_back_to_back_r10();
    pad_en = 1; fcs_en = 1;
    build(0, 100, 20, 0);
    build(200, 64, 46, 0);
    clear_rx();
    for (int i = 0; i < 164; i++) begin
      int base = (i < 100) ? 0 : 100;
      int pos  = (i < 100) ? i : i - 100;
      @(negedge clk);
      in_valid = 1'b1; in_sof = (pos == 0); in_eof = (i == 99 || i == 163);
      in_data = frm[base + (i < 100 ? 0 : 100) + pos];
    end
    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (300) @(posedge clk);
    chk(rx_cnt == 94, "R10 back-to-back total bytes", rx_cnt, 94);
    compare("R10 back-to-back frame A", 0, 0, 34);
    compare("R10 back-to-back frame B", 34, 200, 60);
    chk(rx_eofs == 2 && eof_pos[0] == 34 && eof_pos[1] == 94, "R10 back-to-back end markers",
        eof_pos[1], 94);
    chk(st_cnt == 2 && st_len[0] == 34 && st_len[1] == 60, "R9 back-to-back status",
        st_len[1], 60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    run_frame("R2 passthrough",           64,  46,     0, 0, 0, 0, 64);
    run_frame("R3 fcs strip short",       64,  46,     0, 1, 0, 0, 60);
    run_frame("R4 pad cut fcs off",       64,  10,     1, 0, 0, 0, 24);
    run_frame("R4 pad cut with gaps",     100, 20,     1, 1, 0, 1, 34);
    run_frame("R4 pad cut at 127",        127, 5,      1, 0, 0, 0, 19);
    run_frame("R5 128 bytes no pad cut",  128, 5,      1, 0, 0, 0, 128);
    run_frame("R5 R3 long fcs strip",     150, 5,      1, 1, 0, 0, 146);
    run_frame("R6 type field kept",       64,  16'h0800, 1, 0, 0, 0, 64);
    run_frame("R7 no padding keeps fcs",  70,  52,     1, 0, 0, 0, 70);
    run_frame("R8 bad crc pad cut",       64,  10,     1, 0, 1, 0, 24);
    t_back_to_back_r10();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule